// File: doc/BRIEF.md
# Asynchronous Serial Character Framer

This block turns parallel bytes into asynchronous serial characters and back again. A line configuration word sets the framing: 5 to 8 data bits sent least significant bit first, an optional parity bit (odd, even, or held at a fixed level), and a stop period of one, one and a half, or two bit times. The block has one holding register and one shift register on the send side. The receive side works the same way, so one character can wait while another is on the wire.

All timing comes from a single-cycle enable, `tick16`, which fires sixteen times per bit period (the oversampling factor is a parameter). A divisor outside the block produces it. The receiver confirms a start bit at its middle and samples each following bit at its middle. It then posts the character together with parity, framing and break indications. A host reads the received byte through `rhr_rd` and acknowledges error flags through `lsr_rd`. A break control in the line configuration holds the serial output low.

Top module: `uart_framer`

## Requirements
- R1: While reset is asserted and directly after it, `ser_out` is 1, `rhr_data` is 0x00 and `line_status` is 0x60.
- R2: `line_cfg[1:0]` gives the word length, 00=5, 01=6, 10=7, 11=8 bits. A frame is a 0 start bit followed by the data bits, least significant first. Each bit lasts 16 ticks. Received bytes carry zeros above the word length.
- R3: Stop time is 16 ticks when `line_cfg[2]`=0. When `line_cfg[2]`=1 it is 24 ticks for 5-bit words and 32 ticks for the other lengths.
- R4: `line_cfg[3]` adds a parity bit after the data. When `line_cfg[5]`=0, `line_cfg[4]`=1 selects even parity and 0 selects odd parity. When `line_cfg[5]`=1, the parity bit is the inverse of `line_cfg[4]`. The receiver sets `line_status[2]` when the received parity bit differs from the value expected under the same rule.
- R5: While `line_cfg[6]` is 1, `ser_out` is 0, whatever the transmitter is doing.
- R6: `line_status[5]` is 1 when the transmit holding register is empty. `line_status[6]` is 1 only when the holding register and the shift register are both empty.
- R7: A low pulse on `ser_in` that has ended before the middle of the start bit is discarded and produces no character.
- R8: A completed character sets `line_status[0]` and appears on `rhr_data`. A `rhr_rd` pulse clears `line_status[0]`.
- R9: If a character completes while `line_status[0]` is 1 and no read happens in that cycle, `line_status[1]` is set, the new character is dropped and `rhr_data` keeps the old byte.
- R10: `line_status[3]` is set when the first stop bit samples 0. `line_status[4]` is also set when the data, the parity and that stop sample are all 0.
- R11: A `lsr_rd` pulse clears `line_status[4:1]`. If a flag is set in the same cycle as the clear, the flag stays set.
- R12: If a character completes in the same cycle as a `rhr_rd` pulse, the new character is accepted and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse, OVS pulses per bit time |
| line_cfg | input | 7 | Framing: word length, stop, parity enable, even select, fixed parity, break |
| thr_wr | input | 1 | Write `thr_data` into the transmit holding register |
| thr_data | input | 8 | Byte to transmit |
| rhr_rd | input | 1 | Read strobe for the received byte |
| lsr_rd | input | 1 | Read strobe for the status; clears the error flags |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |
| rhr_data | output | 8 | Last accepted received byte |
| line_status | output | 8 | {0, tx empty, holding empty, break, framing, parity, overrun, data ready} |

## Verification
Two events can land on the same clock edge: a character finishing at its stop sample, and a host strobe. The strobe is either the byte read or the status read. The bench first times a character sent from an empty state to find the exact edge where data-ready rises. It then sends an identical character, with the same phase relative to `tick16`, and fires the strobe on that edge. A byte read on that edge must leave the new byte stored with no overrun. A status read on that edge must leave the framing flag set.

// File: rtl/uart_framer_pkg.sv
package uart_framer_pkg;

   // Field order matches the bit order of the line configuration word.
   typedef struct packed {
      logic       brk;
      logic       stick;
      logic       even;
      logic       par_en;
      logic       stop_x;
      logic [1:0] wlen;
   } line_cfg_t;

   typedef enum logic [2:0] {
      FR_IDLE, FR_START, FR_DATA, FR_PAR, FR_STOP, FR_HOLD
   } frame_st_e;

   function automatic logic [7:0] mask_word(logic [7:0] d, logic [1:0] wlen);
      return d & (8'hFF >> (2'd3 - wlen));
   endfunction

   function automatic logic par_bit(logic [7:0] d, line_cfg_t c);
      if (c.stick) return ~c.even;
      return c.even ? ^d : ~(^d);
   endfunction

   function automatic int unsigned stop_ticks(line_cfg_t c, int unsigned ovs);
      if (!c.stop_x) return ovs;
      if (c.wlen == 2'd0) return ovs + ovs / 2;
      return 2 * ovs;
   endfunction

endpackage

// File: rtl/uart_fr_tx.sv
module uart_fr_tx
   import uart_framer_pkg::*;
#(
   parameter int OVS   = 16,
   parameter int CNT_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  line_cfg_t  cfg,
   input  logic       hold_full,
   input  logic [7:0] hold_data,
   output logic       take,
   output logic       busy,
   output logic       line
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

   frame_st_e        st;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       idx;
   logic [7:0]       sh;
   logic             pbit;
   logic [CNT_W-1:0] stop_end;
   logic [7:0]       word;
   logic             unused_tx;

   assign unused_tx = cfg.brk;
   assign stop_end  = CNT_W'(stop_ticks(cfg, OVS) - 1);
   assign word      = mask_word(hold_data, cfg.wlen);
   assign take      = (st == FR_IDLE) && hold_full;
   assign busy      = (st != FR_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= FR_IDLE;
         cnt  <= '0;
         idx  <= '0;
         sh   <= '0;
         pbit <= 1'b0;
      end else begin
         case (st)
            FR_IDLE: if (hold_full) begin
               sh   <= word;
               pbit <= par_bit(word, cfg);
               cnt  <= '0;
               idx  <= '0;
               st   <= FR_START;
            end
            FR_START: if (tick) begin
               if (cnt == LAST) begin cnt <= '0; st <= FR_DATA; end
               else cnt <= cnt + 1'b1;
            end
            FR_DATA: if (tick) begin
               if (cnt == LAST) begin
                  cnt <= '0;
                  sh  <= sh >> 1;
                  if (idx == ({1'b0, cfg.wlen} + 3'd4)) st <= cfg.par_en ? FR_PAR : FR_STOP;
                  else idx <= idx + 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            FR_PAR: if (tick) begin
               if (cnt == LAST) begin cnt <= '0; st <= FR_STOP; end
               else cnt <= cnt + 1'b1;
            end
            FR_STOP: if (tick) begin
               if (cnt == stop_end) begin cnt <= '0; st <= FR_IDLE; end
               else cnt <= cnt + 1'b1;
            end
            default: st <= FR_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st)
         FR_START: line = 1'b0;
         FR_DATA:  line = sh[0];
         FR_PAR:   line = pbit;
         default:  line = 1'b1;
      endcase
   end
endmodule

// File: rtl/uart_fr_rx.sv
module uart_fr_rx
   import uart_framer_pkg::*;
#(
   parameter int OVS   = 16,
   parameter int CNT_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  line_cfg_t  cfg,
   input  logic       rx,
   output logic       done,
   output logic [7:0] data,
   output logic       perr,
   output logic       ferr,
   output logic       brk
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS / 2 - 1);

   frame_st_e        st;
   logic [CNT_W-1:0] cnt;
   logic [2:0]       idx;
   logic [7:0]       sh;
   logic             pbit_s;
   logic             zeros;
   logic             rx_prev;
   logic             unused_rx;

   assign unused_rx = ^{cfg.brk, cfg.stop_x};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FR_IDLE;
         cnt     <= '0;
         idx     <= '0;
         sh      <= '0;
         pbit_s  <= 1'b0;
         zeros   <= 1'b1;
         rx_prev <= 1'b1;
         done    <= 1'b0;
         data    <= '0;
         perr    <= 1'b0;
         ferr    <= 1'b0;
         brk     <= 1'b0;
      end else begin
         rx_prev <= rx;
         done    <= 1'b0;
         case (st)
            FR_IDLE: if (rx_prev && !rx) begin
               cnt <= '0;
               st  <= FR_START;
            end
            FR_START: if (tick) begin
               if (cnt == HALF) begin
                  if (rx) st <= FR_IDLE;
                  else begin
                     cnt   <= '0;
                     idx   <= '0;
                     sh    <= '0;
                     zeros <= 1'b1;
                     st    <= FR_DATA;
                  end
               end else cnt <= cnt + 1'b1;
            end
            FR_DATA: if (tick) begin
               if (cnt == LAST) begin
                  cnt     <= '0;
                  sh[idx] <= rx;
                  if (rx) zeros <= 1'b0;
                  if (idx == ({1'b0, cfg.wlen} + 3'd4)) st <= cfg.par_en ? FR_PAR : FR_STOP;
                  else idx <= idx + 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            FR_PAR: if (tick) begin
               if (cnt == LAST) begin
                  cnt    <= '0;
                  pbit_s <= rx;
                  if (rx) zeros <= 1'b0;
                  st     <= FR_STOP;
               end else cnt <= cnt + 1'b1;
            end
            FR_STOP: if (tick) begin
               if (cnt == LAST) begin
                  cnt  <= '0;
                  done <= 1'b1;
                  data <= sh;
                  perr <= cfg.par_en && (pbit_s != par_bit(sh, cfg));
                  ferr <= ~rx;
                  brk  <= ~rx & zeros;
                  st   <= rx ? FR_IDLE : FR_HOLD;
               end else cnt <= cnt + 1'b1;
            end
            FR_HOLD: if (rx) st <= FR_IDLE;
            default: st <= FR_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_framer.sv
module uart_framer
   import uart_framer_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic [6:0] line_cfg,
   input  logic       thr_wr,
   input  logic [7:0] thr_data,
   input  logic       rhr_rd,
   input  logic       lsr_rd,
   input  logic       ser_in,
   output logic       ser_out,
   output logic [7:0] rhr_data,
   output logic [7:0] line_status
);
   localparam int CNT_W = $clog2(2 * OVS);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 to 4");
   end

   line_cfg_t  cfg;
   logic       rx_s;
   logic       thr_full;
   logic [7:0] thr_q;
   logic       tx_take, tx_busy, tx_line;
   logic       rx_done, rx_perr, rx_ferr, rx_brk;
   logic [7:0] rx_data;
   logic       dr, oe, pe, fe, bi, accept;

   assign cfg = line_cfg_t'(line_cfg);

   if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = ser_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sq <= '1;
         else begin
            sq[0] <= ser_in;
            for (int i = 1; i < SYNC_STAGES; i++) sq[i] <= sq[i-1];
         end
      end
      assign rx_s = sq[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_full <= 1'b0;
         thr_q    <= '0;
      end else if (thr_wr) begin
         thr_full <= 1'b1;
         thr_q    <= thr_data;
      end else if (tx_take) begin
         thr_full <= 1'b0;
      end
   end

   uart_fr_tx #(.OVS(OVS), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .cfg(cfg),
      .hold_full(thr_full), .hold_data(thr_q),
      .take(tx_take), .busy(tx_busy), .line(tx_line)
   );

   uart_fr_rx #(.OVS(OVS), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .cfg(cfg), .rx(rx_s),
      .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr), .brk(rx_brk)
   );

   assign accept = rx_done && (!dr || rhr_rd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rhr_data <= '0;
         dr <= 1'b0; oe <= 1'b0; pe <= 1'b0; fe <= 1'b0; bi <= 1'b0;
      end else begin
         if (accept) begin
            rhr_data <= rx_data;
            dr       <= 1'b1;
         end else if (rhr_rd) begin
            dr <= 1'b0;
         end
         oe <= (oe && !lsr_rd) || (rx_done && !accept);
         pe <= (pe && !lsr_rd) || (accept && rx_perr);
         fe <= (fe && !lsr_rd) || (accept && rx_ferr);
         bi <= (bi && !lsr_rd) || (accept && rx_brk);
      end
   end

   assign ser_out     = cfg.brk ? 1'b0 : tx_line;
   assign line_status = {1'b0, !thr_full && !tx_busy, !thr_full, bi, fe, pe, oe, dr};
endmodule

// File: rtl/uart_framer_chk.sv
module uart_framer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       thr_wr,
   input logic       rhr_rd,
   input logic       brk_cfg,
   input logic       ser_out,
   input logic       rx_done,
   input logic [7:0] rhr_data,
   input logic [7:0] line_status
);
   logic unused_chk;
   assign unused_chk = ^{line_status[7], line_status[4:2]};

   assert_thr_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !line_status[5]);

   assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (line_status[6] && !brk_cfg) |-> ser_out);

   assert_overrun_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_status[1]) |-> ($stable(rhr_data) && line_status[0]));

   assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rhr_rd && !rx_done) |=> !line_status[0]);

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ser_out) && !brk_cfg && !$past(brk_cfg)) |-> !line_status[6]);
endmodule

bind uart_framer uart_framer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .rhr_rd(rhr_rd),
   .brk_cfg(line_cfg[6]), .ser_out(ser_out), .rx_done(rx_done),
   .rhr_data(rhr_data), .line_status(line_status)
);

// File: tb/uart_framer_bench.sv
`timescale 1ns/1ps
module uart_framer_bench;
   logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
   logic [6:0] cfg = '0;
   logic       thr_wr = 1'b0, rhr_rd = 1'b0, lsr_rd = 1'b0, ser_in = 1'b1;
   logic [7:0] thr_data = '0;
   wire        ser_out;
   wire  [7:0] rhr_data, lsr;
   int unsigned cyc = 0;
   int checks = 0, fails = 0, dr_at = -1;
   logic [1:0] ph = '0;

   uart_framer u_uart_framer (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_cfg(cfg),
      .thr_wr(thr_wr), .thr_data(thr_data), .rhr_rd(rhr_rd), .lsr_rd(lsr_rd),
      .ser_in(ser_in), .ser_out(ser_out), .rhr_data(rhr_data), .line_status(lsr)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      ph     <= ph + 2'd1;
      tick16 <= (ph == 2'd3);
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clk_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int nb_of(input logic [6:0] c);
      return 5 + int'(c[1:0]);
   endfunction

   function automatic logic exp_par(input logic [7:0] d, input logic [6:0] c);
      logic [7:0] m;
      m = d & 8'((1 << nb_of(c)) - 1);
      if (c[5]) return ~c[4];
      return c[4] ? ^m : ~(^m);
   endfunction

   function automatic int stop_t(input logic [6:0] c);
      if (!c[2]) return 16;
      return (c[1:0] == 2'b00) ? 24 : 32;
   endfunction

   task automatic tx_check(input logic [6:0] c, input logic [7:0] d, input string tag);
      int w, t0, dur, exp;
      cfg = c;
      @(negedge clk); thr_wr = 1'b1; thr_data = d;
      @(negedge clk); thr_wr = 1'b0;
      chk(lsr[5] == 1'b0, {tag, " R6 holding full"}, lsr[5], 0);
      w = 0;
      while (ser_out !== 1'b0 && w < 2000) begin @(negedge clk); w++; end
      t0 = cyc;
      clk_n(32);
      chk(ser_out == 1'b0, {tag, " R2 start"}, ser_out, 0);
      for (int i = 0; i < nb_of(c); i++) begin
         clk_n(64);
         chk(ser_out == d[i], {tag, " R2 data bit"}, ser_out, d[i]);
      end
      if (c[3]) begin
         clk_n(64);
         chk(ser_out == exp_par(d, c), {tag, " R4 parity"}, ser_out, exp_par(d, c));
      end
      clk_n(64);
      chk(ser_out == 1'b1, {tag, " R3 stop level"}, ser_out, 1);
      w = 0;
      while (!lsr[6] && w < 3000) begin @(negedge clk); w++; end
      dur = cyc - t0;
      exp = 64 * (1 + nb_of(c) + (c[3] ? 1 : 0)) + 4 * stop_t(c);
      chk(dur >= exp - 8 && dur <= exp + 8, {tag, " R3 frame length"}, dur, exp);
      chk(lsr[6:5] == 2'b11, {tag, " R6 both empty"}, lsr[6:5], 3);
   endtask

   task automatic build(input logic [6:0] c, input logic [7:0] d, input bit flip,
                        input bit stopv, output logic [15:0] b, output int nb);
      int k;
      b = '1;
      b[0] = 1'b0;
      for (int i = 0; i < nb_of(c); i++) b[1+i] = d[i];
      k = 1 + nb_of(c);
      if (c[3]) begin b[k] = exp_par(d, c) ^ flip; k++; end
      b[k] = stopv;
      nb = k + 1;
   endtask

   // which: 0 none, 1 byte read, 2 status read, pulsed at iteration strobe_at
   task automatic rx_send(input logic [15:0] b, input int nb, input int strobe_at, input int which);
      bit dr_prev;
      while (cyc % 4 != 0) @(negedge clk);
      dr_prev = lsr[0];
      dr_at = -1;
      for (int k = 0; k < nb * 64 + 64; k++) begin
         @(negedge clk);
         if (lsr[0] && !dr_prev && dr_at < 0) dr_at = k;
         dr_prev = lsr[0];
         ser_in  = (k < nb * 64) ? b[k / 64] : 1'b1;
         rhr_rd  = (which == 1 && k == strobe_at);
         lsr_rd  = (which == 2 && k == strobe_at);
      end
      @(negedge clk); rhr_rd = 1'b0; lsr_rd = 1'b0;
   endtask

   task automatic rx_char(input logic [6:0] c, input logic [7:0] d, input bit flip, input bit stopv);
      logic [15:0] b; int nb;
      cfg = c;
      build(c, d, flip, stopv, b, nb);
      rx_send(b, nb, -1, 0);
   endtask

   task automatic rd_rhr;
      @(negedge clk); rhr_rd = 1'b1;
      @(negedge clk); rhr_rd = 1'b0;
   endtask

   task automatic rd_lsr;
      @(negedge clk); lsr_rd = 1'b1;
      @(negedge clk); lsr_rd = 1'b0;
   endtask

   task automatic t_reset;
      clk_n(3);
      chk(ser_out == 1'b1, "R1 line idle in reset", ser_out, 1);
      chk(lsr == 8'h60, "R1 status in reset", lsr, 8'h60);
      chk(rhr_data == 8'h00, "R1 byte in reset", rhr_data, 0);
      rst_n = 1'b1;
      clk_n(2);
      chk(lsr == 8'h60, "R1 status after reset", lsr, 8'h60);
   endtask

   task automatic t_tx_formats;
      tx_check(7'b0000011, 8'hA5, "8N1");
      tx_check(7'b0011100, 8'h13, "5E1.5");
      tx_check(7'b0001110, 8'h5A, "7O2");
      tx_check(7'b0101001, 8'h2A, "6 fixed1");
      tx_check(7'b0111011, 8'hFF, "8 fixed0");
   endtask

   task automatic t_tx_break;
      int w;
      cfg = 7'b1000011;
      @(negedge clk); thr_wr = 1'b1; thr_data = 8'hFF;
      @(negedge clk); thr_wr = 1'b0;
      for (int i = 0; i < 3; i++) begin
         clk_n(150);
         chk(ser_out == 1'b0, "R5 break holds line low", ser_out, 0);
      end
      w = 0;
      while (!lsr[6] && w < 3000) begin @(negedge clk); w++; end
      chk(ser_out == 1'b0, "R5 break after frame", ser_out, 0);
      cfg = 7'b0000011;
      @(negedge clk);
      chk(ser_out == 1'b1, "R5 break released", ser_out, 1);
   endtask

   task automatic t_rx_basic;
      rx_char(7'b0000011, 8'h3C, 0, 1);
      chk(lsr[0] == 1'b1, "R8 data ready", lsr[0], 1);
      chk(rhr_data == 8'h3C, "R8 byte", rhr_data, 8'h3C);
      chk(lsr[4:1] == 4'b0, "R8 no errors", lsr[4:1], 0);
      rd_rhr;
      chk(lsr[0] == 1'b0, "R8 ready cleared by read", lsr[0], 0);
   endtask

   task automatic t_rx_parity;
      rx_char(7'b0011000, 8'h15, 0, 1);
      chk(rhr_data == 8'h15 && lsr[2] == 1'b0, "R4 good even parity", {rhr_data, lsr}, {8'h15, 8'h61});
      rd_rhr;
      rx_char(7'b0011000, 8'h15, 1, 1);
      chk(lsr[2] == 1'b1, "R4 bad even parity flagged", lsr[2], 1);
      rd_lsr;
      chk(lsr[4:1] == 4'b0, "R11 status read clears flags", lsr[4:1], 0);
      rd_rhr;
      rx_char(7'b0111001, 8'hEB, 0, 1);
      chk(lsr[2] == 1'b0, "R4 fixed-0 parity accepted", lsr[2], 0);
      chk(rhr_data == 8'h2B, "R2 six-bit byte zero above", rhr_data, 8'h2B);
      rd_rhr;
      rx_char(7'b0111001, 8'h2B, 1, 1);
      chk(lsr[2] == 1'b1, "R4 fixed-0 parity violated", lsr[2], 1);
      rd_rhr; rd_lsr;
   endtask

   task automatic t_rx_frame_break;
      logic [15:0] b;
      rx_char(7'b0000011, 8'h81, 0, 0);
      chk(lsr[3] == 1'b1 && lsr[4] == 1'b0, "R10 framing without break", lsr, 8'h69);
      rd_rhr; rd_lsr;
      b = '0;
      cfg = 7'b0000011;
      rx_send(b, 12, -1, 0);
      chk(lsr[4] == 1'b1 && lsr[3] == 1'b1, "R10 break and framing", lsr, 8'h79);
      chk(rhr_data == 8'h00, "R10 break byte", rhr_data, 0);
      rd_rhr; rd_lsr;
   endtask

   task automatic t_false_start;
      while (cyc % 4 != 0) @(negedge clk);
      @(negedge clk); ser_in = 1'b0;
      clk_n(16);
      ser_in = 1'b1;
      clk_n(800);
      chk(lsr[0] == 1'b0 && lsr[3] == 1'b0, "R7 glitch ignored", lsr, 8'h60);
   endtask

   task automatic t_overrun_and_collisions;
      logic [15:0] b; int nb, d_ok, d_fe;
      rx_char(7'b0000011, 8'h11, 0, 1);
      d_ok = dr_at;
      rx_char(7'b0000011, 8'h22, 0, 1);
      chk(lsr[1] == 1'b1, "R9 overrun set", lsr[1], 1);
      chk(rhr_data == 8'h11 && lsr[0], "R9 held byte kept", rhr_data, 8'h11);
      rd_rhr; rd_lsr;
      chk(lsr == 8'h60, "R11 all cleared", lsr, 8'h60);
      rx_char(7'b0000011, 8'h33, 0, 1);
      build(7'b0000011, 8'h44, 0, 1, b, nb);
      rx_send(b, nb, d_ok - 1, 1);
      chk(lsr[1] == 1'b0, "R12 no overrun on same-cycle read", lsr[1], 0);
      chk(lsr[0] == 1'b1 && rhr_data == 8'h44, "R12 new byte stored", rhr_data, 8'h44);
      rd_rhr;
      rx_char(7'b0000011, 8'h81, 0, 0);
      d_fe = dr_at;
      rd_rhr; rd_lsr;
      build(7'b0000011, 8'h81, 0, 0, b, nb);
      rx_send(b, nb, d_fe - 1, 2);
      chk(lsr[3] == 1'b1, "R11 set wins over clear", lsr[3], 1);
      rd_rhr; rd_lsr;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset;
      t_tx_formats;
      t_tx_break;
      t_rx_basic;
      t_rx_parity;
      t_rx_frame_break;
      t_false_start;
      t_overrun_and_collisions;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule